// File: doc/BRIEF.md
# Context Validation Tag Generator

This block produces the one-byte validation tag that sits alongside a connection context entry. A request carries a 24-bit connection identifier together with a 4-bit type code and a 4-bit region code. The block packs these into a 32-bit word and runs an 8-bit CRC over the whole word in one combinational step. It then turns the checksum into a tag whose most significant bit marks the entry as valid. The same request port also has an invalidate operation. That operation takes a tag that already exists and hands it back with the validity bit cleared, so a consumer can retire a context and still keep its checksum bits.

Results leave through a registered output. A request accepted on one clock edge gives a result one cycle later. Requests may arrive on every cycle.

A small state machine tracks what the output register holds. It has three states:
- `ST_IDLE`: nothing is presented.
- `ST_TAG`: a freshly generated tag is presented.
- `ST_CLR`: an invalidated tag is presented.

The transition rules are the same from every state. On each edge:
- `GO_IDLE`: if `in_valid` is low, the next state is `ST_IDLE`.
- `GO_TAG`: if `in_valid` is high and `in_inval` is low, the next state is `ST_TAG`.
- `GO_CLR`: if `in_valid` and `in_inval` are both high, the next state is `ST_CLR`.

Top module: `ctag_gen`

## Requirements
- R1: While reset is asserted and after its release with no request, `out_valid` is 0 and `out_tag` is 8'h00.
- R2: The CRC input word holds the connection identifier in bits [31:8], the region in bits [7:4] and the type in bits [3:0].
- R3: The checksum uses the polynomial x^8 + x^2 + x + 1 (8'h07) and starts from 8'hFF. The result equals that of shifting all 32 word bits through a serial LFSR, most significant bit first.
- R4: A generate request (`in_inval` = 0) yields `out_tag[7]` = 1 and `out_tag[6:0]` = checksum bits [6:0].
- R5: An invalidate request (`in_inval` = 1) yields `out_tag` = {1'b0, `in_tag[6:0]`}. The identifier, region and type inputs have no effect on this result.
- R6: `out_valid` is high in the cycle after each edge where `in_valid` is high, and low after each edge where it is low.
- R7: When no request is accepted, `out_tag` keeps its previous value.
- R8: Requests on consecutive cycles each produce their own result on consecutive cycles, in order.
- R9: Region codes 2 and 4, the codes used for aggregation contexts, are handled like any other region value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_inval | input | 1 | 0 = generate a tag, 1 = invalidate `in_tag` |
| in_cid | input | 24 | Connection identifier |
| in_region | input | 4 | Region code |
| in_type | input | 4 | Type code |
| in_tag | input | 8 | Existing tag for the invalidate operation |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_tag | output | 8 | Generated or invalidated tag |

## Verification
The generate path is driven with the following patterns, each compared against a byte-wise serial model:
- an all-zero word, which exposes the seed alone;
- an all-ones word;
- a single one walked through every identifier bit, which shows each column of the parallel matrix;
- a single one walked through the region and type fields, which shows whether the packing places each field in the right slot.

Region codes 2 and 4 are tried with several identifiers. The invalidate path is given tags with bit 7 both set and clear, while the other inputs vary, to show that only bit 7 changes. Back-to-back bursts with idle gaps between them separate per-cycle throughput from holding the output while idle.

// File: rtl/ctag_pkg.sv
package ctag_pkg;

    localparam int unsigned CID_W_DEF   = 24;
    localparam int unsigned FIELD_W_DEF = 4;
    localparam int unsigned TAG_W_DEF   = 8;
    localparam logic [7:0]  POLY_DEF    = 8'h07;
    localparam logic [7:0]  SEED_DEF    = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TAG  = 2'd1,
        ST_CLR  = 2'd2
    } ctag_state_e;

endpackage

// File: rtl/ctag_pack.sv
module ctag_pack #(
    parameter int unsigned CID_W   = 24,
    parameter int unsigned FIELD_W = 4,
    localparam int unsigned WORD_W = CID_W + 2 * FIELD_W
) (
    input  logic [CID_W-1:0]   cid,
    input  logic [FIELD_W-1:0] region,
    input  logic [FIELD_W-1:0] kind,
    output logic [WORD_W-1:0]  word
);
    localparam logic [FIELD_W-1:0] FMASK = '1;

    // identifier on top, region in the middle, type at the bottom
    assign word = {cid, region & FMASK, kind & FMASK};
endmodule

// File: rtl/ctag_crc.sv
module ctag_crc #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CRC_W  = 8,
    parameter logic [CRC_W-1:0] POLY = 8'h07,
    parameter logic [CRC_W-1:0] SEED = 8'hFF
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    // Unrolled serial LFSR, MSB first; elaborates into a flat XOR network.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = SEED;
        fb  = 1'b0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY;
            end
        end
        crc = acc;
    end
endmodule

// File: rtl/ctag_fold.sv
module ctag_fold #(
    parameter int unsigned TAG_W = 8
) (
    input  logic [TAG_W-1:0] crc,
    input  logic [TAG_W-1:0] old_tag,
    input  logic             inval,
    output logic [TAG_W-1:0] tag
);
    always_comb begin
        if (inval) begin
            tag = {1'b0, old_tag[TAG_W-2:0]};
        end else begin
            tag = {1'b1, crc[TAG_W-2:0]};
        end
    end
endmodule

// File: rtl/ctag_gen.sv
module ctag_gen
    import ctag_pkg::*;
#(
    parameter int unsigned CID_W   = CID_W_DEF,
    parameter int unsigned FIELD_W = FIELD_W_DEF,
    parameter int unsigned TAG_W   = TAG_W_DEF,
    parameter logic [TAG_W-1:0] POLY = POLY_DEF,
    parameter logic [TAG_W-1:0] SEED = SEED_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic               in_inval,
    input  logic [CID_W-1:0]   in_cid,
    input  logic [FIELD_W-1:0] in_region,
    input  logic [FIELD_W-1:0] in_type,
    input  logic [TAG_W-1:0]   in_tag,
    output logic               out_valid,
    output logic [TAG_W-1:0]   out_tag
);
    localparam int unsigned WORD_W = CID_W + 2 * FIELD_W;

    logic [WORD_W-1:0] word;
    logic [TAG_W-1:0]  crc;
    logic [TAG_W-1:0]  tag_d;
    logic [TAG_W-1:0]  tag_q;
    ctag_state_e       state, state_nxt;

    ctag_pack #(.CID_W(CID_W), .FIELD_W(FIELD_W)) u_pack (
        .cid    (in_cid),
        .region (in_region),
        .kind   (in_type),
        .word   (word)
    );

    ctag_crc #(.DATA_W(WORD_W), .CRC_W(TAG_W), .POLY(POLY), .SEED(SEED)) u_crc (
        .data (word),
        .crc  (crc)
    );

    ctag_fold #(.TAG_W(TAG_W)) u_fold (
        .crc     (crc),
        .old_tag (in_tag),
        .inval   (in_inval),
        .tag     (tag_d)
    );

    // next state: GO_IDLE / GO_TAG / GO_CLR, identical from every state
    always_comb begin
        unique case (state)
            ST_IDLE, ST_TAG, ST_CLR: begin
                if (!in_valid)     state_nxt = ST_IDLE;
                else if (in_inval) state_nxt = ST_CLR;
                else               state_nxt = ST_TAG;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        tag_q <= '0;
        else if (in_valid) tag_q <= tag_d;
    end

    assign out_valid = (state != ST_IDLE);
    assign out_tag   = tag_q;
endmodule

// File: rtl/ctag_chk.sv
module ctag_chk #(
    parameter int unsigned TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_inval,
    input logic [TAG_W-1:0] in_tag,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag
);
    assert_valid_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_inval) |=> out_tag[TAG_W-1]);

    assert_inval_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_inval) |=> (out_tag == {1'b0, $past(in_tag[TAG_W-2:0])}));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_tag));

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!out_valid && out_tag == '0);
        end
    end
endmodule

bind ctag_gen ctag_chk #(.TAG_W(TAG_W)) u_ctag_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_inval  (in_inval),
    .in_tag    (in_tag),
    .out_valid (out_valid),
    .out_tag   (out_tag)
);

// File: tb/test_ctag_gen.sv
`timescale 1ns/100ps
module test_ctag_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_inval = 1'b0;
    logic [23:0] in_cid = '0;
    logic [3:0]  in_region = '0;
    logic [3:0]  in_type = '0;
    logic [7:0]  in_tag = '0;
    logic        out_valid;
    logic [7:0]  out_tag;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    bit          done = 1'b0;
    bit          mon_on = 1'b0;
    logic [7:0]  exp_q[$];
    string       req_q[$];
    logic [7:0]  last_tag = 8'h00;

    always #2.5 clk = ~clk;

    ctag_gen i_ctag_gen (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inval(in_inval),
        .in_cid(in_cid), .in_region(in_region), .in_type(in_type), .in_tag(in_tag),
        .out_valid(out_valid), .out_tag(out_tag)
    );

    // byte-wise reference: MSB-first, poly 0x07, seed 0xFF (R2, R3)
    function automatic logic [7:0] ref_crc(logic [23:0] c, logic [3:0] r, logic [3:0] t);
        logic [31:0] w;
        logic [7:0]  x;
        w = {c, r, t};
        x = 8'hFF;
        for (int b = 3; b >= 0; b--) begin
            x = x ^ w[b*8 +: 8];
            for (int k = 0; k < 8; k++) begin
                x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
            end
        end
        return x;
    endfunction

    task automatic check(bit ok, string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic gen(logic [23:0] c, logic [3:0] r, logic [3:0] t, string req);
        @(negedge clk);
        in_valid = 1'b1; in_inval = 1'b0;
        in_cid = c; in_region = r; in_type = t; in_tag = $urandom;
        exp_q.push_back({1'b1, ref_crc(c, r, t)[6:0]});   // R4
        req_q.push_back(req);
    endtask

    task automatic inval(logic [7:0] old, string req);
        @(negedge clk);
        in_valid = 1'b1; in_inval = 1'b1;
        in_cid = $urandom; in_region = $urandom; in_type = $urandom; in_tag = old;
        exp_q.push_back({1'b0, old[6:0]});                 // R5
        req_q.push_back(req);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_inval = 1'b0;
            in_cid = $urandom; in_region = $urandom; in_type = $urandom; in_tag = $urandom;
        end
    endtask

    // monitor: 1 ns after each edge, compares against the scoreboard
    always @(posedge clk) begin
        #1;
        if (mon_on && !done) begin
            if (exp_q.size() != 0) begin
                logic [7:0] e;
                string      rq;
                e  = exp_q.pop_front();
                rq = req_q.pop_front();
                check(out_valid === 1'b1, {"R6 valid ", rq}, {7'd0, out_valid}, 8'h01);
                check(out_tag === e, rq, out_tag, e);
                last_tag = out_tag;
            end else begin
                check(out_valid === 1'b0, "R6 idle valid", {7'd0, out_valid}, 8'h00);
                check(out_tag === last_tag, "R7 hold", out_tag, last_tag);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hang expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R1 valid in reset", {7'd0, out_valid}, 8'h00);
        check(out_tag === 8'h00, "R1 tag in reset", out_tag, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1 valid after release", {7'd0, out_valid}, 8'h00);
        check(out_tag === 8'h00, "R1 tag after release", out_tag, 8'h00);
        mon_on = 1'b1;
        idle(2);

        gen(24'h000000, 4'h0, 4'h0, "R3 zero word");
        idle(1);
        gen(24'hFFFFFF, 4'hF, 4'hF, "R3 ones word");
        idle(3);
        for (int i = 0; i < 24; i++) gen(24'h1 << i, 4'h0, 4'h0, "R2 R3 cid walk R8");
        idle(2);
        for (int i = 0; i < 4; i++) gen(24'h0, 4'h1 << i, 4'h0, "R2 region walk");
        for (int i = 0; i < 4; i++) gen(24'h0, 4'h0, 4'h1 << i, "R2 type walk");
        idle(1);
        gen(24'h123456, 4'd2, 4'h3, "R9 region 2");
        gen(24'h123456, 4'd4, 4'h3, "R9 region 4");
        gen(24'hABCDEF, 4'd2, 4'h9, "R9 region 2b");
        gen(24'hABCDEF, 4'd4, 4'h9, "R9 region 4b");
        idle(2);
        inval(8'hA5, "R5 inval set");
        inval(8'h3C, "R5 inval clear");
        idle(1);
        inval(8'hFF, "R5 inval ones");
        gen(24'h00BEEF, 4'h4, 4'h1, "R8 mixed gen");
        inval(8'h80, "R8 mixed inval");
        gen(24'hC0FFEE, 4'h2, 4'h7, "R8 mixed gen2");
        idle(4);
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 4) inval($urandom, "R5 random");
            else gen($urandom, $urandom, $urandom, "R3 random");
            if (i % 7 == 6) idle(2);
        end
        idle(4);
        check(exp_q.size() == 0, "R8 drained", 8'(exp_q.size()), 8'h00);
        finish_run();
    end
endmodule